// File: doc/BRIEF.md
# SPI Host Interrupt and Error Aggregator

This block gathers the error and event conditions of an SPI host controller into two interrupt lines: one for errors and one for events. The transfer engine reports errors as single-cycle set pulses and events as status levels. The block keeps the error causes in sticky flags and masks them per cause. It then latches a pending bit per line and drives each interrupt output from that pending bit and the line's enable.

Software reaches the block through a small word-addressed register port. The port has a combinational read path and single-cycle writes. Software can enable each line, mask each error cause and each event cause, clear pending bits and error flags by writing ones, and force either line through a test register. A line takes a new interrupt only while it is enabled and not already pending. A pending line therefore has to be acknowledged before it can fire again.

Top module: `spi_irq_hub`

## Requirements
- R1: After reset, the pending, line-enable, event-mask and error-flag registers read 0, the error-mask register reads 0x1F, and both interrupt outputs are low.
- R2: The register offsets are: 0 pending, 1 line enable, 2 force (test), 3 error mask, 4 error flags, 5 event mask. The other offsets read 0. In the pending, enable and force registers, bit 0 is the error line and bit 1 is the event line.
- R3: Bit k of `err_set_i` sets error flag k at the next edge. The flag bits are: 0 command while busy, 1 overflow, 2 underflow, 3 invalid command, 4 invalid chip select, 5 invalid access. A flag stays set until software writes 1 to it at offset 4. If a set and a clear hit the same flag in the same cycle, the set wins.
- R4: The error line's cause is true when any flag bit k (k from 0 to 4) is set together with error-mask bit k. Flag bit 5 never raises the error line.
- R5: Event-mask bit 0 enables `evt_cond_i[0]` (receive full), bit 1 enables `evt_cond_i[1]` (transmit empty), and bit 4 enables `evt_cond_i[2]` (ready). Event-mask bits 2, 3 and 5 read 0 and have no effect.
- R6: A line is evaluated only when its enable bit is 1 and its pending bit is 0. If it has a cause or a force, its pending bit sets at that edge. While the line is disabled, nothing is latched.
- R7: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged. A pending bit otherwise holds.
- R8: Writing 1 to a bit of the force register triggers that line at the write edge, subject to R6. The force register stores nothing and reads 0.
- R9: Each interrupt output equals its pending bit ANDed with its enable bit.
- R10: Register writes and event conditions act at the edge on which they are sampled. An error pulse reaches its flag at one edge and the error line's pending bit at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset for both read and write |
| reg_wdata_i | input | 6 | Write data |
| reg_rdata_o | output | 6 | Read data for `reg_addr_i`, combinational |
| err_set_i | input | 6 | Error flag set pulses from the transfer engine |
| evt_cond_i | input | 3 | Event condition levels: receive full, transmit empty, ready |
| irq_err_o | output | 1 | Error interrupt level |
| irq_evt_o | output | 1 | Event interrupt level |

## Verification
Some results are due at the first edge after a stimulus: a write, a force, a pending-bit clear and an event condition. An error pulse is due in its flag after one edge, and in the error line's pending bit and output only after a second edge. The reference model in the bench updates on every rising edge from the inputs sampled there, and it carries the flag-then-pending delay as two separate state steps. Both interrupt outputs and the read data are compared on each falling edge, after all registers have settled. The directed checks then sample the read port and the outputs in the low phase right after each write or pulse. These checks probe exactly one edge later and two edges later, which tells the two delays apart.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int ADDR_W     = 3;
    localparam int ERR_FLAGS  = 6;
    localparam int DATA_W     = ERR_FLAGS;
    localparam int ERR_CAUSES = 5;
    localparam int EVT_CONDS  = 3;
    localparam int NUM_LINES  = 2;

    localparam int LINE_ERR = 0;
    localparam int LINE_EVT = 1;

    localparam logic [ADDR_W-1:0] A_PEND  = 3'd0;
    localparam logic [ADDR_W-1:0] A_IEN   = 3'd1;
    localparam logic [ADDR_W-1:0] A_FORCE = 3'd2;
    localparam logic [ADDR_W-1:0] A_EMASK = 3'd3;
    localparam logic [ADDR_W-1:0] A_EFLAG = 3'd4;
    localparam logic [ADDR_W-1:0] A_VMASK = 3'd5;

    // bit position of each event condition inside the event-mask register
    localparam int EVT_BIT_POS [EVT_CONDS] = '{0, 1, 4};

    localparam logic [ERR_CAUSES-1:0] EMASK_RST = '1;

    typedef struct packed {
        logic [NUM_LINES-1:0]  ien;
        logic [ERR_CAUSES-1:0] emask;
        logic [EVT_CONDS-1:0]  vmask;
    } csr_t;

endpackage

// File: rtl/spi_irq_csr.sv
module spi_irq_csr
    import spi_irq_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  we_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [NUM_LINES-1:0]  ien_o,
    output logic [ERR_CAUSES-1:0] emask_o,
    output logic [EVT_CONDS-1:0]  vmask_o,
    output logic [NUM_LINES-1:0]  force_o,
    output logic [NUM_LINES-1:0]  pend_clr_o,
    output logic [ERR_FLAGS-1:0]  flag_clr_o
);

    csr_t csr_d, csr_q;

    always_comb begin
        csr_d      = csr_q;
        force_o    = '0;
        pend_clr_o = '0;
        flag_clr_o = '0;
        if (we_i) begin
            unique case (addr_i)
                A_PEND:  pend_clr_o  = wdata_i[NUM_LINES-1:0];
                A_IEN:   csr_d.ien   = wdata_i[NUM_LINES-1:0];
                A_FORCE: force_o     = wdata_i[NUM_LINES-1:0];
                A_EMASK: csr_d.emask = wdata_i[ERR_CAUSES-1:0];
                A_EFLAG: flag_clr_o  = wdata_i;
                A_VMASK: begin
                    for (int k = 0; k < EVT_CONDS; k++) begin
                        csr_d.vmask[k] = wdata_i[EVT_BIT_POS[k]];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            csr_q.ien   <= '0;
            csr_q.emask <= EMASK_RST;
            csr_q.vmask <= '0;
        end else begin
            csr_q <= csr_d;
        end
    end

    assign ien_o   = csr_q.ien;
    assign emask_o = csr_q.emask;
    assign vmask_o = csr_q.vmask;

    // R8: a force write stores nothing
    p_force_no_store_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == A_FORCE) |=> $stable(csr_q));

    // R7: a pending-clear write leaves the masks untouched
    p_clear_no_store_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == A_PEND) |=> $stable(csr_q));

endmodule

// File: rtl/spi_irq_errlog.sv
module spi_irq_errlog
    import spi_irq_pkg::*;
#(
    parameter int W = ERR_FLAGS
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flags_o
);

    logic [W-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = (flags_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flags_q <= '0;
        else         flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    for (genvar k = 0; k < W; k++) begin : g_chk
        // R3: a set pulse lands in the flag, even against a clear
        p_set_lands_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_i[k] |=> flags_q[k]);
        // R3: a flag is sticky until cleared
        p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (flags_q[k] && !clr_i[k]) |=> flags_q[k]);
        // R3: a clear without a set empties the flag
        p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i[k] && !set_i[k]) |=> !flags_q[k]);
    end

endmodule

// File: rtl/spi_irq_line.sv
module spi_irq_line (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic cause_i,
    input  logic force_i,
    input  logic clr_i,
    output logic pend_o,
    output logic irq_o
);

    logic pend_d, pend_q;

    always_comb begin
        if (!pend_q) pend_d = en_i & (cause_i | force_i);
        else         pend_d = !clr_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q <= 1'b0;
        else         pend_q <= pend_d;
    end

    assign pend_o = pend_q;
    assign irq_o  = pend_q & en_i;

    // R6: an enabled idle line with a trigger latches
    p_latch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !pend_q && (cause_i || force_i)) |=> pend_q);

    // R6: a disabled idle line never latches
    p_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && !pend_q) |=> !pend_q);

    // R7: pending holds until a clear
    p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_q && !clr_i) |=> pend_q);

    // R7: a clear empties it
    p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_q && clr_i) |=> !pend_q);

endmodule

// File: rtl/spi_irq_hub.sv
module spi_irq_hub
    import spi_irq_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 reg_we_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [DATA_W-1:0]    reg_wdata_i,
    output logic [DATA_W-1:0]    reg_rdata_o,
    input  logic [ERR_FLAGS-1:0] err_set_i,
    input  logic [EVT_CONDS-1:0] evt_cond_i,
    output logic                 irq_err_o,
    output logic                 irq_evt_o
);

    logic [NUM_LINES-1:0]  ien, force_p, pend_clr, pend, irq, cause;
    logic [ERR_CAUSES-1:0] emask;
    logic [EVT_CONDS-1:0]  vmask;
    logic [ERR_FLAGS-1:0]  flag_clr, flags;

    spi_irq_csr u_csr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .we_i       (reg_we_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .ien_o      (ien),
        .emask_o    (emask),
        .vmask_o    (vmask),
        .force_o    (force_p),
        .pend_clr_o (pend_clr),
        .flag_clr_o (flag_clr)
    );

    spi_irq_errlog #(.W(ERR_FLAGS)) u_errlog (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (err_set_i),
        .clr_i   (flag_clr),
        .flags_o (flags)
    );

    // per-cause masking; the invalid-access flag has no mask and no line
    always_comb begin
        cause           = '0;
        cause[LINE_ERR] = |(flags[ERR_CAUSES-1:0] & emask);
        cause[LINE_EVT] = |(evt_cond_i & vmask);
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        spi_irq_line u_line (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .en_i    (ien[i]),
            .cause_i (cause[i]),
            .force_i (force_p[i]),
            .clr_i   (pend_clr[i]),
            .pend_o  (pend[i]),
            .irq_o   (irq[i])
        );
    end

    assign irq_err_o = irq[LINE_ERR];
    assign irq_evt_o = irq[LINE_EVT];

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            A_PEND:  reg_rdata_o[NUM_LINES-1:0]  = pend;
            A_IEN:   reg_rdata_o[NUM_LINES-1:0]  = ien;
            A_EMASK: reg_rdata_o[ERR_CAUSES-1:0] = emask;
            A_EFLAG: reg_rdata_o                 = flags;
            A_VMASK: begin
                for (int k = 0; k < EVT_CONDS; k++) begin
                    reg_rdata_o[EVT_BIT_POS[k]] = vmask[k];
                end
            end
            default: ;
        endcase
    end

    // R4: an unmasked cause-free flag state never starts the error line
    p_err_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pend[LINE_ERR] && ((flags[ERR_CAUSES-1:0] & emask) == '0)
         && !force_p[LINE_ERR]) |=> !pend[LINE_ERR]);

    // R9: no output without its enable
    p_out_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ien[LINE_EVT] |-> !irq_evt_o);

endmodule

// File: tb/spi_irq_hub_tb.sv
module spi_irq_hub_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [2:0] addr = '0;
    logic [5:0] wdata = '0;
    logic [5:0] rdata;
    logic [5:0] err_set = '0;
    logic [2:0] evt_cond = '0;
    logic       irq_err, irq_evt;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spi_irq_hub u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .err_set_i   (err_set),
        .evt_cond_i  (evt_cond),
        .irq_err_o   (irq_err),
        .irq_evt_o   (irq_evt)
    );

    // behavioural reference
    bit [1:0] m_pend, m_ien;
    bit [4:0] m_emask;
    bit [5:0] m_flags, m_vmask;

    function automatic bit [5:0] m_read(input bit [2:0] a);
        case (a)
            3'd0: return {4'b0, m_pend};
            3'd1: return {4'b0, m_ien};
            3'd3: return {1'b0, m_emask};
            3'd4: return m_flags;
            3'd5: return m_vmask;
            default: return 6'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 0; m_ien = 0; m_emask = 5'h1F; m_flags = 0; m_vmask = 0;
        end else begin
            bit [1:0] frc, clr, trig;
            bit [5:0] fclr;
            frc  = (we && addr == 3'd2) ? wdata[1:0] : 2'b0;
            clr  = (we && addr == 3'd0) ? wdata[1:0] : 2'b0;
            fclr = (we && addr == 3'd4) ? wdata : 6'b0;
            trig[0] = (|(m_flags[4:0] & m_emask)) | frc[0];
            trig[1] = (evt_cond[0] & m_vmask[0]) | (evt_cond[1] & m_vmask[1])
                    | (evt_cond[2] & m_vmask[4]) | frc[1];
            for (int i = 0; i < 2; i++) begin
                if (m_pend[i]) m_pend[i] = !clr[i];
                else           m_pend[i] = m_ien[i] & trig[i];
            end
            m_flags = (m_flags & ~fclr) | err_set;
            if (we && addr == 3'd1) m_ien = wdata[1:0];
            if (we && addr == 3'd3) m_emask = wdata[4:0];
            if (we && addr == 3'd5) m_vmask = wdata & 6'h13;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_cmp++;
            if (irq_err !== (m_pend[0] & m_ien[0]) || irq_evt !== (m_pend[1] & m_ien[1])) begin
                n_bad++;
                $display("FAIL R9 cycle compare irq got %b%b exp %b%b", irq_evt, irq_err,
                         m_pend[1] & m_ien[1], m_pend[0] & m_ien[0]);
            end
            n_cmp++;
            if (rdata !== m_read(addr)) begin
                n_bad++;
                $display("FAIL R2 cycle compare rdata@%0d got %h exp %h", addr, rdata, m_read(addr));
            end
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic wr(input bit [2:0] a, input bit [5:0] d);
        tick(); we = 1; addr = a; wdata = d;
        tick(); we = 0;
    endtask

    task automatic rd(input bit [2:0] a, input int exp, input string tag);
        addr = a; #1;
        chk(tag, rdata, exp);
    endtask

    task automatic pulse(input bit [5:0] v);
        tick(); err_set = v;
        tick(); err_set = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        tick(); rst_n = 1;
        // R1 reset state
        rd(0, 0, "R1 pend"); rd(1, 0, "R1 ien"); rd(3, 5'h1F, "R1 emask");
        rd(4, 0, "R1 flags"); rd(5, 0, "R1 vmask"); rd(2, 0, "R1 force");
        chk("R1 irq", {irq_evt, irq_err}, 0);
        // R5 unused event-mask bits
        wr(5, 6'h3F); rd(5, 6'h13, "R5 vmask bits"); wr(5, 0);
        // R2 enable readback, R8 force
        wr(1, 3); rd(1, 3, "R2 ien readback");
        wr(2, 2); rd(0, 2, "R8 force latches event");
        chk("R9 evt out", irq_evt, 1); chk("R9 err out", irq_err, 0);
        rd(2, 0, "R8 force reads 0");
        // R7 clear
        wr(0, 0); rd(0, 2, "R7 write 0 keeps");
        wr(0, 2); rd(0, 0, "R7 write 1 clears"); chk("R7 out", irq_evt, 0);
        // R10 two-edge error path, R4
        pulse(6'h02); rd(4, 2, "R3 flag set");
        chk("R10 err not yet", irq_err, 0);
        tick(); chk("R10 err pend", irq_err, 1);
        wr(0, 1); rd(0, 0, "R7 err cleared");
        tick(); rd(0, 1, "R6 retrigger on live cause");
        wr(4, 2); wr(0, 1); tick(); rd(0, 0, "R3 flag cleared stays quiet");
        // R4 invalid access has no line
        pulse(6'h20); tick(); tick();
        chk("R4 bit5 no irq", irq_err, 0); rd(4, 6'h20, "R3 bit5 flag");
        wr(4, 6'h20);
        // R4 mask gate
        wr(3, 5'h1D); pulse(6'h02); tick(); tick();
        chk("R4 masked cause", irq_err, 0);
        wr(3, 5'h1F); chk("R4 unmask edge", irq_err, 0);
        tick(); chk("R4 unmasked cause", irq_err, 1);
        wr(4, 2); wr(0, 1);
        // R3 set wins over clear
        tick(); we = 1; addr = 4; wdata = 6'h01; err_set = 6'h01;
        tick(); we = 0; err_set = 0;
        rd(4, 1, "R3 set beats clear");
        wr(4, 1); wr(0, 1); rd(0, 0, "R3 cleanup");
        // R6 disabled line does not latch
        wr(1, 1); wr(2, 2); rd(0, 0, "R6 force ignored when disabled");
        wr(5, 6'h01); evt_cond = 3'b001; tick(); tick();
        rd(0, 0, "R6 cause ignored when disabled");
        wr(1, 3); chk("R6 enable edge", irq_evt, 0);
        tick(); chk("R6 latches once enabled", irq_evt, 1);
        wr(1, 1); chk("R9 enable off drops out", irq_evt, 0); rd(0, 2, "R9 pend kept");
        wr(1, 3); chk("R9 enable on restores", irq_evt, 1);
        evt_cond = 0; wr(0, 2);
        // R5 ready condition, same-edge timing
        wr(5, 6'h10); tick(); evt_cond = 3'b100; tick();
        chk("R10 event same edge", irq_evt, 1); evt_cond = 0;
        wr(0, 2); wr(5, 6'h04); rd(5, 0, "R5 watermark bit reads 0");
        evt_cond = 3'b111; tick(); tick(); chk("R5 no enabled event", irq_evt, 0);
        evt_cond = 0;
        // random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            tick();
            we = ($urandom % 4) == 0;
            addr = 3'($urandom % 8);
            wdata = 6'($urandom);
            err_set = (($urandom % 8) == 0) ? 6'(1 << ($urandom % 6)) : 6'd0;
            evt_cond = 3'($urandom);
        end
        tick(); we = 0; err_set = 0;
        tick();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule